// File: doc/BRIEF.md
# Serial Transmit Port Controller

This block is the host-facing serial front end of a baseband transmitter. A host frames each packet by holding an enable line active. While the packet is open the block drives a bit clock back to the host. It samples one host data bit on every falling edge of that clock. It hands a bit stream, one valid strobe per bit, to the downstream modulator. When the host releases enable, the bit clock stops and the block pushes a fixed number of zero flush bits into the modulator path.

The block has two framing modes, chosen per packet.

- **Internal framing:** the block first emits its own preamble. The preamble is a configurable number of repetitions of a sync byte, then a start-frame byte, then a header word taken from a configuration input. It raises a ready line a configurable number of bit clocks before the first host bit is needed.
- **External framing:** the host supplies the whole frame from the first bit clock, and ready stays inactive.

The enable, ready and bit clock pins each have their own polarity select. A clear-channel input is visible at the port but never influences transmission.

Top module: `tx_serial_port`

## Requirements
- R1: An active enable in the idle state starts a packet. The bit clock pin toggles while enable stays active. Once the block has seen enable inactive, the bit clock pin holds its inactive level and makes no further rising transitions.
- R2: In internal framing, the stream starts with `cfg_sync_reps` copies of SYNC_PAT (0 copies is allowed), then SFD_PAT, then `cfg_header`. Every field is sent bit 0 first.
- R3: In internal framing, ready becomes active on the bit clock rising edge that starts bit slot N−L, counting slots from 0. N is the preamble length in bits and L is `cfg_lead`, which must be below SFD_W+HDR_W. Ready then stays active until enable is seen inactive.
- R4: In external framing, ready stays at its inactive level. The host bit driven on the first rising bit clock edge is the first bit of the stream.
- R5: Host data is sampled on the falling bit clock edge. The bit the host drives after rising edge L+k, counted from the edge where ready rose, becomes stream bit N+k. In external framing it is the bit driven after rising edge k.
- R6: Each pin level is the logical value XOR its own polarity bit: `cfg_pol_en` for enable, `cfg_pol_rdy` for ready, `cfg_pol_clk` for the bit clock. A polarity bit of 1 means active low.
- R7: The level of `cca_in` has no effect on start-up or on the stream.
- R8: On the first falling edge that finds enable inactive, no bit is captured. Exactly FLUSH_BITS zero bits with valid follow, and then valid stays low.
- R9: `mod_valid` is a one-cycle pulse. Successive pulses are at least one bit period (2·HALF_DIV clocks) apart.
- R10: If enable drops during the preamble, the preamble is cut at that falling edge, ready never rises, and the flush of R8 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_internal | input | 1 | 1 selects internal framing for the next packet |
| cfg_pol_en | input | 1 | Enable pin polarity (1 = active low) |
| cfg_pol_rdy | input | 1 | Ready pin polarity (1 = active low) |
| cfg_pol_clk | input | 1 | Bit clock pin polarity (1 = inverted) |
| cfg_lead | input | LEAD_W | Ready lead in bit clocks |
| cfg_sync_reps | input | REP_W | Number of sync byte repetitions |
| cfg_header | input | HDR_W | Header word, sent bit 0 first |
| cca_in | input | 1 | Clear-channel status, observed only |
| tx_en_pin | input | 1 | Packet enable from the host |
| tx_data_pin | input | 1 | Serial data from the host |
| tx_clk_pin | output | 1 | Bit clock to the host |
| tx_rdy_pin | output | 1 | Ready to the host |
| mod_bit | output | 1 | Bit toward the modulator |
| mod_valid | output | 1 | Strobe for `mod_bit` |

## Verification
The bench builds the block with HALF_DIV=2, so a bit period is only four system clocks. This keeps every packet short enough to run several framing cases in one run. Keeping the 8-bit sync and start-frame bytes and the 16-bit header puts both a zero-repetition preamble and the largest legal lead of 15 within reach. With a 3-bit repetition count and FLUSH_BITS=4, the preamble cut-off and the full flush fit in a few dozen bit periods. Each pin polarity is inverted in one of the packets.

// File: rtl/tx_serial_port.sv
module tx_serial_port #(
  parameter int HALF_DIV = 4,
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB4,
  parameter int SFD_W = 8,
  parameter logic [SFD_W-1:0] SFD_PAT = 8'hE1,
  parameter int HDR_W = 16,
  parameter int REP_W = 3,
  parameter int LEAD_W = 4,
  parameter int FLUSH_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_internal,
  input  logic              cfg_pol_en,
  input  logic              cfg_pol_rdy,
  input  logic              cfg_pol_clk,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic [REP_W-1:0]  cfg_sync_reps,
  input  logic [HDR_W-1:0]  cfg_header,
  input  logic              cca_in,
  input  logic              tx_en_pin,
  input  logic              tx_data_pin,
  output logic              tx_clk_pin,
  output logic              tx_rdy_pin,
  output logic              mod_bit,
  output logic              mod_valid
);

  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int MAX_PRE = (2**REP_W - 1) * SYNC_W + SFD_W + HDR_W;
  localparam int SLOT_W  = $clog2(MAX_PRE + FLUSH_BITS + 2);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_SFD, S_HDR, S_DATA, S_FLUSH} st_t;

  st_t               state_q;
  logic [DIV_W-1:0]  div_q;
  logic              bclk_q;
  logic [SLOT_W-1:0] idx_q, slot_q;
  logic [REP_W-1:0]  rep_q, reps_q;
  logic [LEAD_W-1:0] lead_q;
  logic [HDR_W-1:0]  hdr_q;
  logic              int_q, rdy_q;
  logic              bit_q, valid_q;

  logic en_act, running, wrap, rise_tick, fall_tick, emit, cur_bit;
  logic [SLOT_W-1:0] pre_len, rdy_slot;
  logic [SYNC_W-1:0] sync_sh;
  logic [SFD_W-1:0]  sfd_sh;
  logic [HDR_W-1:0]  hdr_sh;

  assign en_act    = tx_en_pin ^ cfg_pol_en;
  assign running   = state_q != S_IDLE;
  assign wrap      = running && (div_q == DIV_W'(HALF_DIV - 1));
  assign rise_tick = wrap && !bclk_q;
  assign fall_tick = wrap && bclk_q;
  assign emit      = fall_tick && (en_act || state_q == S_FLUSH);

  assign tx_clk_pin = (bclk_q && running && state_q != S_FLUSH) ^ cfg_pol_clk;
  assign tx_rdy_pin = rdy_q ^ cfg_pol_rdy;
  assign mod_bit    = bit_q;
  assign mod_valid  = valid_q;

  assign pre_len  = SLOT_W'(reps_q) * SLOT_W'(SYNC_W) + SLOT_W'(SFD_W + HDR_W);
  assign rdy_slot = pre_len - SLOT_W'(lead_q);

  assign sync_sh = SYNC_PAT >> idx_q;
  assign sfd_sh  = SFD_PAT >> idx_q;
  assign hdr_sh  = hdr_q >> idx_q;

  always_comb begin
    case (state_q)
      S_SYNC:  cur_bit = sync_sh[0];
      S_SFD:   cur_bit = sfd_sh[0];
      S_HDR:   cur_bit = hdr_sh[0];
      S_DATA:  cur_bit = tx_data_pin;
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!running) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      bclk_q <= !bclk_q;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) bit_q <= cur_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      slot_q  <= '0;
      rep_q   <= '0;
      reps_q  <= '0;
      lead_q  <= '0;
      hdr_q   <= '0;
      int_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else if (state_q == S_IDLE) begin
      if (en_act) begin
        int_q  <= cfg_internal;
        reps_q <= cfg_sync_reps;
        lead_q <= cfg_lead;
        hdr_q  <= cfg_header;
        idx_q  <= '0;
        slot_q <= '0;
        rep_q  <= '0;
        rdy_q  <= 1'b0;
        if (!cfg_internal)           state_q <= S_DATA;
        else if (cfg_sync_reps == '0) state_q <= S_SFD;
        else                         state_q <= S_SYNC;
      end
    end else begin
      if (rise_tick && int_q && state_q != S_FLUSH && slot_q == rdy_slot)
        rdy_q <= 1'b1;
      if (fall_tick) begin
        if (state_q == S_FLUSH) begin
          if (idx_q == SLOT_W'(FLUSH_BITS - 1)) state_q <= S_IDLE;
          idx_q <= idx_q + SLOT_W'(1);
        end else if (!en_act) begin
          state_q <= S_FLUSH;
          idx_q   <= '0;
          rdy_q   <= 1'b0;
        end else begin
          if (state_q != S_DATA) slot_q <= slot_q + SLOT_W'(1);
          case (state_q)
            S_SYNC: begin
              if (idx_q == SLOT_W'(SYNC_W - 1)) begin
                idx_q <= '0;
                if (rep_q + REP_W'(1) == reps_q) state_q <= S_SFD;
                else                              rep_q <= rep_q + REP_W'(1);
              end else idx_q <= idx_q + SLOT_W'(1);
            end
            S_SFD: begin
              if (idx_q == SLOT_W'(SFD_W - 1)) begin
                idx_q   <= '0;
                state_q <= S_HDR;
              end else idx_q <= idx_q + SLOT_W'(1);
            end
            S_HDR: begin
              if (idx_q == SLOT_W'(HDR_W - 1)) begin
                idx_q   <= '0;
                state_q <= S_DATA;
              end else idx_q <= idx_q + SLOT_W'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_IDLE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (tx_clk_pin == cfg_pol_clk)); // R1
  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && state_q != S_FLUSH && state_q != S_IDLE) |=> (rdy_q || state_q == S_FLUSH)); // R3
  AST_EXT_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && !int_q) |-> (tx_rdy_pin == cfg_pol_rdy)); // R4
  AST_CCA_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && en_act && cca_in) |=> (state_q != S_IDLE)); // R7
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_FLUSH && mod_valid) |-> !mod_bit); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mod_valid |=> !mod_valid); // R9

endmodule

// File: tb/test_tx_serial_port.sv
module test_tx_serial_port;
  localparam logic [7:0] SYNC = 8'hB4;
  localparam logic [7:0] SFD  = 8'hE1;
  localparam int FLUSH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_internal = 1'b0, cfg_pol_en = 1'b0, cfg_pol_rdy = 1'b0, cfg_pol_clk = 1'b0;
  logic [3:0] cfg_lead = '0;
  logic [2:0] cfg_sync_reps = '0;
  logic [15:0] cfg_header = '0;
  logic cca_in = 1'b0, tx_en_pin = 1'b0, tx_data_pin = 1'b0;
  logic tx_clk_pin, tx_rdy_pin, mod_bit, mod_valid;
  int checks = 0, fails = 0;

  always #2.5 clk = !clk;

  tx_serial_port #(.HALF_DIV(2), .SYNC_W(8), .SYNC_PAT(SYNC), .SFD_W(8), .SFD_PAT(SFD),
    .HDR_W(16), .REP_W(3), .LEAD_W(4), .FLUSH_BITS(FLUSH)) i_tx_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_internal(cfg_internal), .cfg_pol_en(cfg_pol_en),
    .cfg_pol_rdy(cfg_pol_rdy), .cfg_pol_clk(cfg_pol_clk), .cfg_lead(cfg_lead),
    .cfg_sync_reps(cfg_sync_reps), .cfg_header(cfg_header), .cca_in(cca_in),
    .tx_en_pin(tx_en_pin), .tx_data_pin(tx_data_pin), .tx_clk_pin(tx_clk_pin),
    .tx_rdy_pin(tx_rdy_pin), .mod_bit(mod_bit), .mod_valid(mod_valid));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit internal, input int reps, input int lead, input logic [15:0] hdr,
                           input int ndata, input logic [63:0] data, input int abort_at,
                           input bit pe, input bit pr, input bit pc, input bit wiggle_cca, input string tag);
    bit exp_s[256];
    bit got_s[256];
    int nexp = 0, ngot = 0, n_pre, rise_idx = -1, rdy_rise = -1, didx;
    int rises_after = 0, rdy_bad = 0, gap_bad = 0, last_v = -100, mism = -1, tail = 0;
    bit prev = 1'b0, en_on = 1'b1, lclk, rdy;
    n_pre = internal ? reps * 8 + 24 : 0;
    if (internal) begin
      for (int r = 0; r < reps; r++) for (int b = 0; b < 8; b++) exp_s[nexp++] = SYNC[b];
      for (int b = 0; b < 8; b++) exp_s[nexp++] = SFD[b];
      for (int b = 0; b < 16; b++) exp_s[nexp++] = hdr[b];
    end
    if (abort_at >= 0) nexp = abort_at;
    else for (int b = 0; b < ndata; b++) exp_s[nexp++] = data[b];
    for (int b = 0; b < FLUSH; b++) exp_s[nexp++] = 1'b0;

    cfg_internal = internal; cfg_sync_reps = 3'(reps); cfg_lead = 4'(lead); cfg_header = hdr;
    cfg_pol_en = pe; cfg_pol_rdy = pr; cfg_pol_clk = pc;
    @(negedge clk);
    tx_en_pin = !pe;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (wiggle_cca) cca_in = cyc[2];
      lclk = tx_clk_pin ^ pc;
      rdy = tx_rdy_pin ^ pr;
      if (mod_valid) begin
        if (cyc - last_v < 4) gap_bad++;
        last_v = cyc;
        if (ngot < 256) got_s[ngot] = mod_bit;
        ngot++;
      end
      if (!internal && rdy) rdy_bad++;
      if (internal && en_on && rdy_rise >= 0 && !rdy) rdy_bad++;
      if (lclk && !prev) begin
        if (!en_on) rises_after++;
        else begin
          rise_idx++;
          if (internal && rdy && rdy_rise < 0) rdy_rise = rise_idx;
          if (internal) didx = (rdy_rise >= 0) ? rise_idx - rdy_rise - lead : -1;
          else didx = rise_idx;
          if ((abort_at >= 0 && rise_idx == abort_at) || (abort_at < 0 && didx >= ndata)) begin
            en_on = 1'b0;
            tx_en_pin = pe;
          end else if (didx >= 0) tx_data_pin = data[didx];
        end
      end
      prev = lclk;
      if (!en_on && ngot >= nexp) begin
        tail++;
        if (tail > 12) break;
      end
    end
    tx_en_pin = pe;
    for (int b = 0; b < nexp && b < ngot; b++) if (mism < 0 && got_s[b] != exp_s[b]) mism = b;
    check(ngot == nexp, "R8", {tag, " stream length incl. flush"}, ngot, nexp);
    check(mism < 0, internal ? "R2" : "R4", {tag, " stream content, first bad index"}, mism, -1);
    check(rises_after == 0, "R1", {tag, " bit clock rises after enable drop"}, rises_after, 0);
    check((tx_clk_pin == pc) && (tx_rdy_pin == pr), "R6", {tag, " idle pin levels"},
          {tx_clk_pin, tx_rdy_pin}, {pc, pr});
    check(gap_bad == 0, "R9", {tag, " valid spacing violations"}, gap_bad, 0);
    if (internal && abort_at < 0)
      check(rdy_rise == n_pre - lead, "R3", {tag, " ready rise slot"}, rdy_rise, n_pre - lead);
    if (internal && abort_at >= 0)
      check(rdy_rise == -1, "R10", {tag, " ready after abort"}, rdy_rise, -1);
    check(rdy_bad == 0, internal ? "R3" : "R4", {tag, " ready level violations"}, rdy_bad, 0);
  endtask

  task automatic test_reset;
    check(mod_valid == 1'b0, "R8", "reset valid", mod_valid, 0);
    check(tx_clk_pin == 1'b0 && tx_rdy_pin == 1'b0, "R1", "reset pins", {tx_clk_pin, tx_rdy_pin}, 0);
  endtask

  task automatic test_internal_basic;
    run_frame(1, 2, 3, 16'hC35A, 20, 64'h000A_5F3C_9E21_0B77, -1, 0, 0, 0, 0, "R2 int reps2 lead3");
  endtask

  task automatic test_internal_no_sync;
    run_frame(1, 0, 0, 16'h8001, 12, 64'h0000_0000_0000_0F96, -1, 0, 0, 0, 0, "R5 int reps0 lead0");
  endtask

  task automatic test_polarity;
    run_frame(1, 1, 15, 16'h1234, 17, 64'h0000_0000_0001_B0D5, -1, 1, 1, 1, 0, "R6 int inverted lead15");
  endtask

  task automatic test_external_cca;
    run_frame(0, 0, 0, 16'h0, 24, 64'h0000_0000_00C3_A5F1, -1, 0, 0, 0, 1, "R7 ext cca toggling");
  endtask

  task automatic test_abort;
    run_frame(1, 2, 2, 16'hFFFF, 8, 64'hFF, 5, 0, 0, 0, 0, "R10 abort in preamble");
  endtask

  task automatic test_external_single;
    run_frame(0, 0, 0, 16'h0, 1, 64'h1, -1, 0, 1, 1, 0, "R4 ext one bit");
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_internal_basic();
    test_internal_no_sync();
    test_polarity();
    test_external_cca();
    test_abort();
    test_external_single();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule